// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request inputs and asserts one interrupt line towards a processor. A request is captured on a rising edge. Inputs can be blocked one by one through a mask register. Priority is fixed, with input 0 the highest. A request is passed on only when it ranks above every interrupt that is still being serviced. When the processor answers with an acknowledge pulse, the block returns an 8-bit vector. It then moves the winning request from the pending register into the in-service register.

The host reaches the block through a one-bit address. Address 0 is the command port and address 1 is the data port. A command write with bit 4 set starts a configuration sequence. The data writes that follow are taken in turn as the vector base, the cascade word and, when bit 0 of the starting byte was set, a mode word. Outside that sequence, other commands retire one in-service bit or choose which status register is read back. Data-port writes and reads go to the mask. When the acknowledge finds nothing to pass on, the block reports a spurious interrupt on input 7.

Top module: `pic_core`

## Requirements
- R1: After reset the pending and in-service registers are 0, the mask is 0xFF, reads from address 0 return the pending register, `casc_cfg_o` is 0 and `int_o` is low.
- R2: A command write with bit 4 set starts the configuration sequence. The next data writes load the vector base, then the cascade word, then (only if bit 0 of the starting byte was 1) the mode word. These writes leave the mask unchanged, and `int_o` stays low until the sequence is complete.
- R3: The vector for input n is the base plus n, taken modulo 256.
- R4: The cascade word last written in a configuration sequence is shown on `casc_cfg_o`.
- R5: A pending bit is set by a rising edge on its input and cleared while that input is low. An input held high after its acknowledge does not raise a new request.
- R6: `int_o` is high only when an unmasked pending input exists and the lowest-numbered one has a smaller index than every set in-service bit.
- R7: `vec_valid_o` is high in the cycle after a one-cycle `ack_i` pulse, and `vec_o` then holds the vector. A forwarded winner has its pending bit cleared and its in-service bit set.
- R8: When bit 1 of the mode word is 1, an acknowledge leaves the in-service register unchanged.
- R9: Command byte 0x0B makes address-0 reads return the in-service register. Command byte 0x0A makes them return the pending register.
- R10: Command byte 0x60+n (n in 0..7) clears in-service bit n and no other bit.
- R11: Outside the configuration sequence, data writes load the mask and data reads return it. A mask bit of 1 keeps that input from `int_o`.
- R12: An acknowledge while `int_o` is low returns the vector for input 7. It leaves the in-service register unchanged, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed port |
| irq_in | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | `vec_o` is valid this cycle |
| casc_cfg_o | output | 8 | Stored cascade configuration word |

## Verification
The priority resolver is driven with pairs of inputs where both members are unmasked, where only the lower-ranked one is unmasked, and where every input is masked. These patterns separate a correct lowest-index pick from a masking fault or a highest-index pick. Nested service is checked by raising a lower-ranked input and then a higher-ranked one while an interrupt is in service. Specific end-of-interrupt is then shown to retire only its own bit. Requests that vanish before the acknowledge, and acknowledges with nothing unmasked, must both produce the input-7 vector with the in-service register left unchanged. A vector base near 255 checks that the addition wraps.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DW  = 8;
  localparam int NIN = 8;
  localparam int IW  = $clog2(NIN);

  typedef enum logic [1:0] {ST_READY, ST_BASE, ST_CASC, ST_MODE} cfg_st_e;

  // {valid, index} of the lowest set bit (highest priority)
  function automatic logic [IW:0] pick_first(input logic [NIN-1:0] v);
    pick_first = '0;
    for (int i = NIN - 1; i >= 0; i--)
      if (v[i]) pick_first = {1'b1, IW'(i)};
  endfunction

  function automatic logic [NIN-1:0] onehot(input logic [IW-1:0] idx);
    onehot = NIN'(1) << idx;
  endfunction

  function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] base,
                                           input logic [IW-1:0] idx);
    vec_of = base + DW'(idx);
  endfunction
endpackage

// File: rtl/pic_regif.sv
module pic_regif import pic_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_cfg,
  output logic [DW-1:0] mask,
  output logic          aeoi,
  output logic          sel_isr,
  output logic          eoi_stb,
  output logic [IW-1:0] eoi_idx
);
  cfg_st_e st;
  logic    need_mode;

  wire start    = cmd_wr && wdata[4];
  wire rd_sel_c = cmd_wr && ready && !wdata[7] && !wdata[4] && wdata[3] && wdata[1];

  assign ready   = (st == ST_READY);
  assign eoi_stb = cmd_wr && ready && (wdata[7:3] == 5'b01100);
  assign eoi_idx = wdata[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_READY;
      need_mode <= 1'b0;
      vec_base  <= '0;
      casc_cfg  <= '0;
      aeoi      <= 1'b0;
      mask      <= '1;
      sel_isr   <= 1'b0;
    end else begin
      if (start) begin
        st        <= ST_BASE;
        need_mode <= wdata[0];
        aeoi      <= 1'b0;
      end else if (dat_wr) begin
        case (st)
          ST_READY: mask <= wdata;
          ST_BASE: begin
            vec_base <= wdata;
            st       <= ST_CASC;
          end
          ST_CASC: begin
            casc_cfg <= wdata;
            st       <= need_mode ? ST_MODE : ST_READY;
          end
          default: begin
            aeoi <= wdata[1];
            st   <= ST_READY;
          end
        endcase
      end
      if (rd_sel_c) sel_isr <= wdata[0];
    end
  end

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ready) |=> $stable(mask));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture import pic_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] irq_in,
  input  logic [NIN-1:0] clr,
  output logic [NIN-1:0] irr
);
  logic [NIN-1:0] prev;
  logic [NIN-1:0] rise;

  assign rise = irq_in & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= (irr | rise) & irq_in & ~clr;
    end
  end

  for (genvar g = 0; g < NIN; g++) begin : g_chk
    assert_edge_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> irr[g]);
    assert_low_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[g] |=> !irr[g]);
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio import pic_pkg::*; (
  input  logic           ready,
  input  logic [NIN-1:0] irr,
  input  logic [NIN-1:0] mask,
  input  logic [NIN-1:0] isr,
  output logic           fwd,
  output logic [IW-1:0]  win_idx
);
  logic [IW:0] req_pick;
  logic [IW:0] isr_pick;

  assign req_pick = pick_first(irr & ~mask);
  assign isr_pick = pick_first(isr);
  assign win_idx  = req_pick[IW-1:0];
  assign fwd      = ready && req_pick[IW] &&
                    (!isr_pick[IW] || (req_pick[IW-1:0] < isr_pick[IW-1:0]));
endmodule

// File: rtl/pic_core.sv
module pic_core import pic_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NIN-1:0] irq_in,
  output logic          int_o,
  input  logic          ack_i,
  output logic [DW-1:0] vec_o,
  output logic          vec_valid_o,
  output logic [DW-1:0] casc_cfg_o
);
  logic           ready, aeoi, sel_isr, eoi_stb, fwd;
  logic [DW-1:0]  vec_base, mask;
  logic [IW-1:0]  eoi_idx, win_idx;
  logic [NIN-1:0] irr, isr, irr_clr, isr_set, isr_clr;
  logic           ack_take;

  pic_regif u_regif (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_en && !addr), .dat_wr(wr_en && addr), .wdata(wdata),
    .ready(ready), .vec_base(vec_base), .casc_cfg(casc_cfg_o), .mask(mask),
    .aeoi(aeoi), .sel_isr(sel_isr), .eoi_stb(eoi_stb), .eoi_idx(eoi_idx)
  );

  pic_req_capture u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(irr_clr), .irr(irr)
  );

  pic_prio u_prio (
    .ready(ready), .irr(irr), .mask(mask), .isr(isr),
    .fwd(fwd), .win_idx(win_idx)
  );

  assign int_o    = fwd;
  assign ack_take = ack_i && fwd;
  assign irr_clr  = ack_take ? onehot(win_idx) : '0;
  assign isr_set  = (ack_take && !aeoi) ? onehot(win_idx) : '0;
  assign isr_clr  = eoi_stb ? onehot(eoi_idx) : '0;
  assign rdata    = addr ? mask : (sel_isr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr         <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      isr         <= (isr & ~isr_clr) | isr_set;
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_of(vec_base, ack_take ? win_idx : IW'(NIN - 1));
    end
  end

  assert_ack_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);
  assert_spur_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> (vec_o == vec_of($past(vec_base), IW'(NIN - 1))));
  assert_spur_isr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi_stb) |=> $stable(isr));
  assert_aeoi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi && !eoi_stb) |=> $stable(isr));
  assert_eoi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && !ack_i) |=> !isr[$past(eoi_idx)]);
  assert_fwd_unmasked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !mask[win_idx]);
  assert_fwd_outranks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (DW'(isr << (IW'(NIN - 1) - win_idx)) == '0));
  assert_cfg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_o);
endmodule

// File: tb/test_pic_core.sv
module test_pic_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       int_o;
  logic       ack_i = 1'b0;
  logic [7:0] vec_o;
  logic       vec_valid_o;
  logic [7:0] casc_cfg_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pic_core i_pic_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_o(int_o), .ack_i(ack_i),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o), .casc_cfg_o(casc_cfg_o)
  );

  // {mask, inputs, forwarded, expected winner (7 when spurious)}
  localparam logic [31:0] TBL [8] = '{
    {8'h00, 8'h81, 8'd1, 8'd0},
    {8'h01, 8'h81, 8'd1, 8'd7},
    {8'h00, 8'h0C, 8'd1, 8'd2},
    {8'hFF, 8'hFF, 8'd0, 8'd7},
    {8'hF0, 8'hF8, 8'd1, 8'd3},
    {8'h00, 8'h00, 8'd0, 8'd7},
    {8'h7F, 8'h40, 8'd0, 8'd7},
    {8'h00, 8'h80, 8'd1, 8'd7}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ack(input string tag, input logic [7:0] exp_vec);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    check({tag, " valid"}, 8'(vec_valid_o), 8'd1);
    check({tag, " vector"}, vec_o, exp_vec);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 int", 8'(int_o), 8'd0);
    rd(1'b0, d); check("R1 pending", d, 8'h00);
    rd(1'b1, d); check("R1 mask", d, 8'hFF);
    check("R1 casc", casc_cfg_o, 8'h00);
    // R5 and R9: masked edge still lands in the pending register
    irq_in = 8'h20; @(negedge clk);
    rd(1'b0, d); check("R5 R9 pending", d, 8'h20);
    check("R11 masked int", 8'(int_o), 8'd0);
    irq_in = 8'h00; @(negedge clk);
    rd(1'b0, d); check("R5 drop", d, 8'h00);
    // R2 configuration
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    check("R4 casc", casc_cfg_o, 8'h04);
    rd(1'b1, d); check("R2 mask kept", d, 8'hFF);
    wr(1'b1, 8'h5A);
    rd(1'b1, d); check("R11 mask rw", d, 8'h5A);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R9 isr sel", d, 8'h00);

    // table of priority and masking patterns (R6 R7 R11 R12)
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m, p, f, w;
      {m, p, f, w} = TBL[k];
      wr(1'b1, m);
      irq_in = p; @(negedge clk);
      check($sformatf("R6 R11 int row%0d", k), 8'(int_o), f);
      ack($sformatf("R7 R12 row%0d", k), 8'h20 + w);
      rd(1'b0, d);
      check($sformatf("R7 R12 isr row%0d", k), d, (f != 0) ? (8'h01 << w) : 8'h00);
      if (f != 0) wr(1'b0, 8'h60 + w);
      irq_in = 8'h00; @(negedge clk);
    end

    // nested service (R6 R10 R5)
    wr(1'b1, 8'h00);
    irq_in = 8'h08; @(negedge clk);
    ack("R7 nest3", 8'h23);
    rd(1'b0, d); check("R7 isr3", d, 8'h08);
    irq_in = 8'h28; @(negedge clk);
    check("R6 lower blocked", 8'(int_o), 8'd0);
    irq_in = 8'h2A; @(negedge clk);
    check("R6 higher passes", 8'(int_o), 8'd1);
    ack("R6 nest1", 8'h21);
    rd(1'b0, d); check("R7 isr nested", d, 8'h0A);
    wr(1'b0, 8'h63);
    rd(1'b0, d); check("R10 only bit3", d, 8'h02);
    check("R6 still blocked", 8'(int_o), 8'd0);
    wr(1'b0, 8'h61);
    check("R10 unblocks", 8'(int_o), 8'd1);
    ack("R6 nest5", 8'h25);
    wr(1'b0, 8'h65);
    check("R5 held high no rerequest", 8'(int_o), 8'd0);
    irq_in = 8'h00; @(negedge clk);
    // request vanishes before acknowledge (R12)
    irq_in = 8'h04; @(negedge clk);
    check("R12 raised", 8'(int_o), 8'd1);
    irq_in = 8'h00; @(negedge clk);
    check("R12 vanished", 8'(int_o), 8'd0);
    ack("R12 vanish", 8'h27);
    rd(1'b0, d); check("R12 isr", d, 8'h00);

    // reconfigure with automatic EOI and a wrapping base (R2 R3 R4 R8)
    wr(1'b0, 8'h11);
    irq_in = 8'h40; @(negedge clk);
    check("R2 quiet during cfg", 8'(int_o), 8'd0);
    wr(1'b1, 8'hFC);
    wr(1'b1, 8'h02);
    check("R2 quiet before mode", 8'(int_o), 8'd0);
    wr(1'b1, 8'h03);
    check("R2 int after cfg", 8'(int_o), 8'd1);
    check("R4 casc", casc_cfg_o, 8'h02);
    rd(1'b1, d); check("R2 mask kept", d, 8'h00);
    ack("R3 wrap", 8'h02);
    rd(1'b0, d); check("R8 isr untouched", d, 8'h00);
    ack("R3 R12 spurious wrap", 8'h03);
    irq_in = 8'h00; @(negedge clk);
    // back to pending view (R9)
    wr(1'b0, 8'h0A);
    irq_in = 8'h90; @(negedge clk);
    rd(1'b0, d); check("R9 pending sel", d, 8'h90);
    irq_in = 8'h00; @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule